// File: doc/BRIEF.md
# Pointer-Value Line Scanner Prefetcher

This block watches cache line fills and looks through each filled line for data words that seem to be addresses. A 32-bit word is taken as a pointer when its top twelve bits (bits 31 down to 20) equal the top twelve bits of the address of the line it was found in. For every such word the block produces a prefetch request for the line that word points into. It learns nothing and keeps no table, so a pointer to a line that has never been touched is just as likely to be prefetched as any other.

A filled line of 64 bytes (sixteen words) arrives in one cycle. All sixteen comparisons run in parallel. The matching words are written into an eight-entry queue in the same clock edge, lowest word index first. The queue offers one line-aligned prefetch address at a time to the memory side. That side takes it by raising a ready signal. Candidates that do not fit in the queue are thrown away, and a saturating counter records how many were lost.

Top module: `ptr_scan_prefetcher`

## Requirements
- R1: A word of the filled line is a candidate only when `fill_valid` is high, the word is not zero, and the word's bits 31:20 equal bits 31:20 of `fill_addr`. Word k of the line is `fill_data[32k+31:32k]`.
- R2: A word of value zero is never a candidate, even when `fill_addr` bits 31:20 are also zero.
- R3: A prefetch address is the candidate word with its bits 5:0 cleared, so it is aligned to a 64-byte line.
- R4: A candidate whose aligned address equals `fill_addr` with bits 5:0 cleared is suppressed. It produces no request and is not counted as dropped.
- R5: Accepted candidates leave the block in ascending word-index order. One leaves on each clock edge where `pf_valid` and `pf_ready` are both high.
- R6: `pf_valid` is high from the edge that captures a fill with at least one accepted candidate. While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged.
- R7: The queue holds 8 entries. The free space for a fill is 8 minus the occupancy before that edge; a pop on the same edge does not add space. Candidates beyond the free space are dropped, highest word indices first.
- R8: `drop_count` grows by the number of dropped candidates of each fill and saturates at 16'hFFFF.
- R9: After reset, `pf_valid` is low and `drop_count` is zero.
- R10: While `fill_valid` is low, the data on `fill_addr` and `fill_data` adds no entry to the queue.
- R11: The block is stateless with respect to addresses: presenting the same line again yields the same prefetch addresses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | A filled line is present this cycle |
| fill_addr | input | 32 | Address of the filled line |
| fill_data | input | 512 | Line contents, word k in bits 32k+31:32k |
| pf_ready | input | 1 | Memory side accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_addr | output | 32 | Line-aligned prefetch address |
| drop_count | output | 16 | Saturating count of candidates lost to a full queue |

## Verification
The scanner is given lines of several kinds. One mixes a matching pointer with an unrelated value. One holds words whose tags differ from the line's tag by one step up or down, and a word that points back into the line itself. One has a zero tag region, where zero words must stay silent. One has scattered matches at low and high word positions to expose the issue order. A line in which all sixteen words match fills the queue and shows which candidates are dropped. It also tests the same-edge free-space rule, and, repeated thousands of times, the saturation of the drop counter. A line repeated after draining shows that no history alters the result, and a line held on the data pins with the valid low shows that only qualified fills reach the queue.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] addr_t;

    typedef struct packed {
        logic  hit;
        addr_t target;
    } cand_t;

    // Clear the low offset bits of an address.
    function automatic addr_t line_base(addr_t a, int unsigned ofs);
        return (a >> ofs) << ofs;
    endfunction

    // True when the bits from position lo upward agree.
    function automatic logic same_region(addr_t w, addr_t l, int unsigned lo);
        return ((w ^ l) >> lo) == '0;
    endfunction

endpackage

// File: rtl/cdp_word_match.sv
module cdp_word_match
    import cdp_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int TAG_LO = 20,
    parameter int OFS_W  = 6
) (
    input  logic                      valid,
    input  addr_t                     line_addr,
    input  logic [WORDS*WORD_W-1:0]   data,
    output logic [WORDS-1:0]          hit,
    output addr_t [WORDS-1:0]         target
);

    addr_t own_line;
    assign own_line = line_base(line_addr, OFS_W);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        addr_t word;
        cand_t cand;

        assign word = data[g*WORD_W +: WORD_W];

        always_comb begin
            cand.target = line_base(word, OFS_W);
            cand.hit    = valid
                       && (word != '0)
                       && same_region(word, line_addr, TAG_LO)
                       && (cand.target != own_line);
        end

        assign hit[g]    = cand.hit;
        assign target[g] = cand.target;
    end

endmodule

// File: rtl/cdp_rank.sv
module cdp_rank #(
    parameter int WORDS = 16,
    parameter int PTR_W = 3,
    parameter int OCC_W = 4,
    parameter int RUN_W = 9
) (
    input  logic [WORDS-1:0]            hit,
    input  logic [OCC_W-1:0]            free,
    output logic [WORDS-1:0]            accept,
    output logic [WORDS-1:0][PTR_W-1:0] slot,
    output logic [RUN_W-1:0]            n_hit,
    output logic [OCC_W-1:0]            n_acc
);

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] took;

    // Lower word indices claim queue slots first.
    always_comb begin
        run  = '0;
        took = '0;
        for (int i = 0; i < WORDS; i++) begin
            accept[i] = hit[i] && (run < RUN_W'(free));
            slot[i]   = run[PTR_W-1:0];
            if (hit[i]) begin
                run = run + RUN_W'(1);
            end
            if (accept[i]) begin
                took = took + RUN_W'(1);
            end
        end
        n_hit = run;
        n_acc = OCC_W'(took);
    end

endmodule

// File: rtl/cdp_queue.sv
module cdp_queue
    import cdp_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int OCC_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WORDS-1:0]            wr_en,
    input  logic [WORDS-1:0][PTR_W-1:0] wr_slot,
    input  addr_t [WORDS-1:0]           wr_data,
    input  logic [OCC_W-1:0]            wr_cnt,
    input  logic                        pop,
    output addr_t                       head,
    output logic [OCC_W-1:0]            occ
);

    addr_t            mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;
    logic [PTR_W-1:0] idx [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            idx[i] = wp + wr_slot[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (wr_en[i]) begin
                mem[idx[i]] <= wr_data[i];
            end
        end
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            wp  <= wp + PTR_W'(wr_cnt);
            if (pop) begin
                rp <= rp + PTR_W'(1);
            end
            occ <= occ + wr_cnt - OCC_W'(pop);
        end
    end

    assign head = mem[rp];

endmodule

// File: rtl/cdp_sat_count.sv
module cdp_sat_count #(
    parameter int W     = 16,
    parameter int INC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     value
);

    logic [W:0] sum;
    assign sum = {1'b0, value} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (sum[W]) begin
            value <= '1;
        end else begin
            value <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/ptr_scan_prefetcher.sv
module ptr_scan_prefetcher
    import cdp_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int TAG_LO     = 20,
    parameter int FIFO_DEPTH = 8,
    parameter int DROP_W     = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   fill_valid,
    input  logic [WORD_W-1:0]                      fill_addr,
    input  logic [(LINE_BYTES*8/WORD_W)*WORD_W-1:0] fill_data,
    input  logic                                   pf_ready,
    output logic                                   pf_valid,
    output logic [WORD_W-1:0]                      pf_addr,
    output logic [DROP_W-1:0]                      drop_count
);

    localparam int WORDS = LINE_BYTES * 8 / WORD_W;
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int OCC_W = $clog2(FIFO_DEPTH + 1);
    localparam int RUN_W = $clog2(WORDS + 1) + OCC_W;

    logic [WORDS-1:0]            hit;
    addr_t [WORDS-1:0]           target;
    logic [WORDS-1:0]            accept;
    logic [WORDS-1:0][PTR_W-1:0] slot;
    logic [RUN_W-1:0]            n_hit;
    logic [OCC_W-1:0]            n_acc;
    logic [OCC_W-1:0]            occ_q;
    logic [OCC_W-1:0]            free;
    logic [RUN_W-1:0]            dropped;
    logic                        pop;
    addr_t                       head;

    cdp_word_match #(
        .WORDS  (WORDS),
        .TAG_LO (TAG_LO),
        .OFS_W  (OFS_W)
    ) u_match (
        .valid     (fill_valid),
        .line_addr (fill_addr),
        .data      (fill_data),
        .hit       (hit),
        .target    (target)
    );

    // Space is judged before this edge's pop.
    assign free = OCC_W'(FIFO_DEPTH) - occ_q;

    cdp_rank #(
        .WORDS (WORDS),
        .PTR_W (PTR_W),
        .OCC_W (OCC_W),
        .RUN_W (RUN_W)
    ) u_rank (
        .hit    (hit),
        .free   (free),
        .accept (accept),
        .slot   (slot),
        .n_hit  (n_hit),
        .n_acc  (n_acc)
    );

    assign pf_valid = (occ_q != '0);
    assign pop      = pf_valid && pf_ready;

    cdp_queue #(
        .WORDS (WORDS),
        .DEPTH (FIFO_DEPTH),
        .PTR_W (PTR_W),
        .OCC_W (OCC_W)
    ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_slot (slot),
        .wr_data (target),
        .wr_cnt  (n_acc),
        .pop     (pop),
        .head    (head),
        .occ     (occ_q)
    );

    assign pf_addr = head;
    assign dropped = n_hit - RUN_W'(n_acc);

    cdp_sat_count #(
        .W     (DROP_W),
        .INC_W (RUN_W)
    ) u_drops (
        .clk   (clk),
        .rst   (rst),
        .inc   (dropped),
        .value (drop_count)
    );

endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
    parameter int DEPTH  = 8,
    parameter int OCC_W  = 4,
    parameter int OFS_W  = 6,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fill_valid,
    input logic              pf_ready,
    input logic              pf_valid,
    input logic [31:0]       pf_addr,
    input logic [DROP_W-1:0] drop_count,
    input logic [OCC_W-1:0]  occ
);

    localparam logic [31:0] OFS_MASK = (32'd1 << OFS_W) - 32'd1;

    a_r6_hold_head: assert property (@(posedge clk) disable iff (rst)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr & OFS_MASK) == 32'd0);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));

    a_r10_idle_steady: assert property (@(posedge clk) disable iff (rst)
        !fill_valid && !pf_ready |=> $stable(occ));

    a_r5_single_pop: assert property (@(posedge clk) disable iff (rst)
        !fill_valid && pf_valid && pf_ready |=> occ == $past(occ) - OCC_W'(1));

    a_r8_drop_monotone: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> drop_count >= $past(drop_count));

endmodule

bind ptr_scan_prefetcher cdp_checker #(
    .DEPTH  (FIFO_DEPTH),
    .OCC_W  (OCC_W),
    .OFS_W  (OFS_W),
    .DROP_W (DROP_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .fill_valid (fill_valid),
    .pf_ready   (pf_ready),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr),
    .drop_count (drop_count),
    .occ        (occ_q)
);

// File: tb/test_ptr_scan_prefetcher.sv
module test_ptr_scan_prefetcher;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 16;
    localparam int DEPTH      = 8;
    localparam int N_VEC      = 4;

    // Stimulus lines and the number of requests each must yield.
    localparam logic [31:0] TBL_ADDR [N_VEC] = '{
        32'h8001_1100, 32'h1234_5040, 32'h0000_0080, 32'hFFF0_0000
    };
    localparam logic [31:0] TBL_WORDS [N_VEC][WORDS] = '{
        '{32'h4037_3551, 32'h8002_2220, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
          32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{32'h1230_0000, 32'h1234_5044, 32'h0, 32'h123F_FFFF, 32'h1240_0000, 32'h1220_0000,
          32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF,
          32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{32'h0, 32'h0000_0004, 32'h0, 32'h000F_FFFF, 32'h0, 32'h0, 32'h0, 32'h0,
          32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
        '{32'hFFF8_0000, 32'h0, 32'hFFF0_003F, 32'h0, 32'h0, 32'hFFF0_0040, 32'h0, 32'h0,
          32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFF1_2345}
    };
    localparam int TBL_CNT [N_VEC] = '{1, 2, 2, 4};

    logic         clk = 1'b0;
    logic         rst;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [511:0] fill_data;
    logic         pf_ready;
    logic         pf_valid;
    logic [31:0]  pf_addr;
    logic [15:0]  drop_count;

    int  checks = 0;
    int  fails  = 0;
    int  drops_exp = 0;
    bit  done = 1'b0;

    logic [31:0] cur_w [WORDS];
    logic [31:0] exp_q [WORDS];
    int          exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_scan_prefetcher i_ptr_scan_prefetcher (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr),
        .drop_count (drop_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Expected request list built from the requirements R1-style rules.
    task automatic model(input logic [31:0] a);
        exp_n = 0;
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] w;
            w = cur_w[i];
            if (w != 32'h0 && w[31:20] == a[31:20] && {w[31:6], 6'b0} != {a[31:6], 6'b0}) begin
                exp_q[exp_n] = {w[31:6], 6'b0};
                exp_n++;
            end
        end
    endtask

    task automatic pack_line(input logic [31:0] a);
        fill_addr = a;
        for (int i = 0; i < WORDS; i++) begin
            fill_data[i*32 +: 32] = cur_w[i];
        end
    endtask

    task automatic apply_line(input logic [31:0] a);
        @(negedge clk);
        pack_line(a);
        fill_valid = 1'b1;
        pf_ready   = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            check(pf_valid == 1'b1, req, "pf_valid during drain", {31'b0, pf_valid}, 32'h1);
            check(pf_addr == exp_q[k], req, "pf_addr in order", pf_addr, exp_q[k]);
            pf_ready = 1'b1;
            @(negedge clk);
        end
        pf_ready = 1'b0;
        check(pf_valid == 1'b0, req, "queue empty after drain", {31'b0, pf_valid}, 32'h0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        fill_valid = 1'b0;
        fill_addr  = '0;
        fill_data  = '0;
        pf_ready   = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check(pf_valid == 1'b0, "R9", "pf_valid after reset", {31'b0, pf_valid}, 32'h0);
        check(drop_count == 16'h0, "R9", "drop_count after reset", {16'b0, drop_count}, 32'h0);

        // R10: a matching line with fill_valid low must not enter
        for (int i = 0; i < WORDS; i++) cur_w[i] = 32'h8001_0000 + 32'(i) * 32'h100;
        pack_line(32'h8000_0000);
        fill_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(pf_valid == 1'b0, "R10", "no request without fill_valid", {31'b0, pf_valid}, 32'h0);

        // Table walk: R1, R2, R3, R4, R5
        for (int v = 0; v < N_VEC; v++) begin
            for (int i = 0; i < WORDS; i++) cur_w[i] = TBL_WORDS[v][i];
            model(TBL_ADDR[v]);
            check(exp_n == TBL_CNT[v], "R1", "candidate count of vector", 32'(exp_n), 32'(TBL_CNT[v]));
            apply_line(TBL_ADDR[v]);
            drain(TBL_CNT[v], v == 2 ? "R2" : (v == 1 ? "R4" : "R5"));
            check(drop_count == 16'(drops_exp), "R3", "no drops on small line",
                  {16'b0, drop_count}, 32'(drops_exp));
        end

        // R11: same line again gives the same requests
        for (int i = 0; i < WORDS; i++) cur_w[i] = TBL_WORDS[1][i];
        model(TBL_ADDR[1]);
        apply_line(TBL_ADDR[1]);
        // R6: head held while pf_ready low
        repeat (3) begin
            @(negedge clk);
            check(pf_valid == 1'b1 && pf_addr == exp_q[0], "R6", "head held without ready",
                  pf_addr, exp_q[0]);
        end
        drain(exp_n, "R11");

        // R7: sixteen matches, eight fit, the higher eight drop
        for (int i = 0; i < WORDS; i++) cur_w[i] = 32'hA000_0100 + 32'(i) * 32'h40;
        model(32'hA000_0000);
        apply_line(32'hA000_0000);
        drops_exp += WORDS - DEPTH;
        check(drop_count == 16'(drops_exp), "R8", "drops from full line",
              {16'b0, drop_count}, 32'(drops_exp));
        // R7: same line while full, with a pop on the same edge: all drop
        @(negedge clk);
        fill_valid = 1'b1;
        pf_ready   = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
        pf_ready   = 1'b0;
        drops_exp += WORDS;
        check(drop_count == 16'(drops_exp), "R7", "pop does not free space same edge",
              {16'b0, drop_count}, 32'(drops_exp));
        for (int k = 0; k < DEPTH - 1; k++) exp_q[k] = exp_q[k+1];
        drain(DEPTH - 1, "R7");

        // R8: saturation
        apply_line(32'hA000_0000);
        @(negedge clk);
        fill_valid = 1'b1;
        repeat (4200) @(negedge clk);
        check(drop_count == 16'hFFFF, "R8", "drop_count saturated", {16'b0, drop_count}, 32'hFFFF);
        @(negedge clk);
        fill_valid = 1'b0;
        check(drop_count == 16'hFFFF, "R8", "drop_count stays saturated", {16'b0, drop_count}, 32'hFFFF);

        // R9: reset from a busy state
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pf_valid == 1'b0, "R9", "pf_valid after busy reset", {31'b0, pf_valid}, 32'h0);
        check(drop_count == 16'h0, "R9", "drop_count after busy reset", {16'b0, drop_count}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule